// File: doc/BRIEF.md
# Column Sorter by Repeated Maximum

This block takes one image column of up to five 8-bit samples per clock and returns the same samples in ascending order, smallest in the bottom lane and largest in the top lane. It is the front end of a two-dimensional rank filter: each sorted column is then shifted into the window store, which is built elsewhere.

It does not use compare-exchange cells. A chain of identical stages sorts the column. Each stage runs a masked search for the largest sample still unclaimed and writes that winner into its own output lane. It then clears the winner's mask bit so that later stages cannot pick it again. The search works bit by bit from the MSB down. At each bit it keeps only the candidates that hold a one, whenever at least one candidate does. When several equal samples share the maximum, only the lowest-indexed one is claimed, so repeated values keep their multiplicity. There is a register after every stage, so the block accepts a new column on every clock and has a fixed latency.

The caller chooses two things with each column. The first is how many rows are active: rows outside that count are masked before the first search, and their output lanes read zero. The second is an inversion flag that complements every active sample before sorting. This lets a downstream rank selector reach low ranks with the same maximum-based machinery.

Top module: `colsort_top`

## Requirements
- R1: When `out_valid` is high, the lanes of `out_col` are non-decreasing from lane 0 (bits 7:0, bottom) to lane 4 (bits 39:32, top).
- R2: A column presented with `in_valid` high at clock edge k appears with `out_valid` high at edge k+5 (one cycle per row lane). Columns may arrive on every clock.
- R3: The sorted output is a permutation of the active (possibly inverted) input samples. Equal values keep their count.
- R4: With `row_count` = n, only input lanes 0..n-1 take part. The values on lanes n and above have no effect on the output, and the lowest 5-n output lanes are zero.
- R5: `row_count` = 0 gives an all-zero column with `out_valid` high. Values 6 and 7 behave as 5.
- R6: With `low_rank` high, every active sample is bitwise complemented before sorting, and the output carries the complemented values.
- R7: While `rst_n` is low, and in the first cycles after its release, `out_valid` is low and `out_col` is all zero.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low and `out_col` all zero at the same latency. Data on such cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input column qualifier |
| in_col | input | 40 | Input samples, lane i in bits 8i+7:8i |
| low_rank | input | 1 | Complement samples before sorting |
| row_count | input | 3 | Number of active rows for this column |
| out_valid | output | 1 | Output column qualifier |
| out_col | output | 40 | Sorted samples, lane 0 smallest |

## Verification
The checker assumes that `row_count` and `low_rank` are sampled together with each valid column and may change on every column. It does not assume that idle cycles carry clean data. Its content check compares the sum of the output lanes with the sum of the active, possibly complemented inputs from five cycles earlier. Together with the ordering and zero-lane checks, this catches a lost or duplicated sample in most cases. The stimulus deliberately drives random garbage on idle cycles and on masked lanes, uses row counts above the lane count, and mixes bubbles into back-to-back streams. The reference model's exact comparison then covers what the sum cannot.

// File: rtl/colsort_pkg.sv
package colsort_pkg;
    localparam int unsigned DEF_ROWS = 5;
    localparam int unsigned DEF_DW   = 8;

    // width of a count that can hold 0..rows
    function automatic int unsigned cnt_width(input int unsigned rows);
        return $clog2(rows + 1);
    endfunction
endpackage

// File: rtl/colsort_maxfind.sv
module colsort_maxfind #(
    parameter int unsigned ROWS = colsort_pkg::DEF_ROWS,
    parameter int unsigned DW   = colsort_pkg::DEF_DW,
    localparam int unsigned W   = ROWS * DW
) (
    input  logic [W-1:0]    data_i,
    input  logic [ROWS-1:0] mask_i,
    output logic [DW-1:0]   max_o,
    output logic [ROWS-1:0] win_o
);
    logic [ROWS-1:0] cand;
    logic [ROWS-1:0] hits;
    logic            taken;

    // bit-serial elimination from MSB down
    always_comb begin
        cand  = mask_i;
        hits  = '0;
        max_o = '0;
        for (int b = DW - 1; b >= 0; b--) begin
            for (int r = 0; r < ROWS; r++) begin
                hits[r] = cand[r] & data_i[r*DW + b];
            end
            max_o[b] = |hits;
            if (|hits) begin
                cand = hits;
            end
        end
        // lowest-index survivor is the single winner
        win_o = '0;
        taken = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            if (cand[r] && !taken) begin
                win_o[r] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/colsort_prep.sv
module colsort_prep #(
    parameter int unsigned ROWS = colsort_pkg::DEF_ROWS,
    parameter int unsigned DW   = colsort_pkg::DEF_DW,
    parameter int unsigned CW   = colsort_pkg::cnt_width(ROWS),
    localparam int unsigned W   = ROWS * DW
) (
    input  logic            in_valid,
    input  logic [W-1:0]    in_col,
    input  logic            low_rank,
    input  logic [CW-1:0]   row_count,
    output logic            valid_o,
    output logic [W-1:0]    data_o,
    output logic [ROWS-1:0] mask_o
);
    logic act;

    always_comb begin
        valid_o = in_valid;
        data_o  = '0;
        mask_o  = '0;
        act     = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            act = in_valid && (i < int'(row_count));
            mask_o[i] = act;
            if (act) begin
                data_o[i*DW +: DW] = in_col[i*DW +: DW] ^ {DW{low_rank}};
            end
        end
    end
endmodule

// File: rtl/colsort_stage.sv
module colsort_stage #(
    parameter int unsigned ROWS = colsort_pkg::DEF_ROWS,
    parameter int unsigned DW   = colsort_pkg::DEF_DW,
    parameter int unsigned IDX  = 0,
    localparam int unsigned W    = ROWS * DW,
    localparam int unsigned LANE = ROWS - 1 - IDX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [W-1:0]    data_i,
    input  logic [ROWS-1:0] mask_i,
    input  logic [W-1:0]    res_i,
    output logic            valid_o,
    output logic [W-1:0]    data_o,
    output logic [ROWS-1:0] mask_o,
    output logic [W-1:0]    res_o
);
    typedef struct packed {
        logic            valid;
        logic [W-1:0]    data;
        logic [ROWS-1:0] mask;
        logic [W-1:0]    res;
    } stage_t;

    stage_t          st_d, st_q;
    logic [DW-1:0]   mx;
    logic [ROWS-1:0] win;

    colsort_maxfind #(.ROWS(ROWS), .DW(DW)) u_max (
        .data_i (data_i),
        .mask_i (mask_i),
        .max_o  (mx),
        .win_o  (win)
    );

    always_comb begin
        st_d = '0;
        if (valid_i) begin
            st_d.valid = 1'b1;
            st_d.data  = data_i;
            st_d.mask  = mask_i & ~win;
            st_d.res   = res_i;
            st_d.res[LANE*DW +: DW] = mx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign mask_o  = st_q.mask;
    assign res_o   = st_q.res;
endmodule

// File: rtl/colsort_top.sv
module colsort_top #(
    parameter int unsigned ROWS = colsort_pkg::DEF_ROWS,
    parameter int unsigned DW   = colsort_pkg::DEF_DW,
    localparam int unsigned CW  = colsort_pkg::cnt_width(ROWS),
    localparam int unsigned W   = ROWS * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_col,
    input  logic          low_rank,
    input  logic [CW-1:0] row_count,
    output logic          out_valid,
    output logic [W-1:0]  out_col
);
    logic            v_ch [0:ROWS];
    logic [W-1:0]    d_ch [0:ROWS];
    logic [ROWS-1:0] m_ch [0:ROWS];
    logic [W-1:0]    r_ch [0:ROWS];
    logic            unused_tail;

    colsort_prep #(.ROWS(ROWS), .DW(DW), .CW(CW)) u_prep (
        .in_valid  (in_valid),
        .in_col    (in_col),
        .low_rank  (low_rank),
        .row_count (row_count),
        .valid_o   (v_ch[0]),
        .data_o    (d_ch[0]),
        .mask_o    (m_ch[0])
    );

    assign r_ch[0] = '0;

    for (genvar s = 0; s < ROWS; s++) begin : g_stage
        colsort_stage #(.ROWS(ROWS), .DW(DW), .IDX(s)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (v_ch[s]),
            .data_i  (d_ch[s]),
            .mask_i  (m_ch[s]),
            .res_i   (r_ch[s]),
            .valid_o (v_ch[s+1]),
            .data_o  (d_ch[s+1]),
            .mask_o  (m_ch[s+1]),
            .res_o   (r_ch[s+1])
        );
    end

    assign out_valid   = v_ch[ROWS];
    assign out_col     = r_ch[ROWS];
    assign unused_tail = ^{d_ch[ROWS], m_ch[ROWS]};
endmodule

// File: rtl/colsort_chk.sv
module colsort_chk #(
    parameter int unsigned ROWS = colsort_pkg::DEF_ROWS,
    parameter int unsigned DW   = colsort_pkg::DEF_DW,
    parameter int unsigned CW   = colsort_pkg::cnt_width(ROWS),
    localparam int unsigned W   = ROWS * DW,
    localparam int unsigned SW  = DW + CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  in_col,
    input logic          low_rank,
    input logic [CW-1:0] row_count,
    input logic          out_valid,
    input logic [W-1:0]  out_col
);
    logic          vh_q [ROWS];
    logic [CW-1:0] ch_q [ROWS];
    logic [SW-1:0] sh_q [ROWS];
    logic [SW-1:0] in_sum, out_sum;
    logic [CW-1:0] eff;
    logic          ordered_ok, zeros_ok;

    always_comb begin
        eff    = (int'(row_count) > ROWS) ? CW'(ROWS) : row_count;
        in_sum = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (i < int'(eff)) begin
                in_sum = in_sum + SW'(in_col[i*DW +: DW] ^ {DW{low_rank}});
            end
        end
    end

    always_comb begin
        out_sum    = '0;
        ordered_ok = 1'b1;
        zeros_ok   = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            out_sum = out_sum + SW'(out_col[i*DW +: DW]);
            if (i < ROWS - 1 && out_col[i*DW +: DW] > out_col[(i+1)*DW +: DW]) begin
                ordered_ok = 1'b0;
            end
            if (i < ROWS - int'(ch_q[ROWS-1]) && out_col[i*DW +: DW] != '0) begin
                zeros_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                vh_q[i] <= 1'b0;
                ch_q[i] <= '0;
                sh_q[i] <= '0;
            end
        end else begin
            vh_q[0] <= in_valid;
            ch_q[0] <= eff;
            sh_q[0] <= in_sum;
            for (int i = 1; i < ROWS; i++) begin
                vh_q[i] <= vh_q[i-1];
                ch_q[i] <= ch_q[i-1];
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ordered_ok); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vh_q[ROWS-1]); // R2
    AST_CONTENT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == sh_q[ROWS-1])); // R3
    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> zeros_ok); // R4
    AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_col == '0)); // R8
endmodule

bind colsort_top colsort_chk #(.ROWS(ROWS), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_col    (in_col),
    .low_rank  (low_rank),
    .row_count (row_count),
    .out_valid (out_valid),
    .out_col   (out_col)
);

// File: tb/colsort_top_tb.sv
`timescale 1ns/1ps
module colsort_top_tb;
    localparam int ROWS = 5;
    localparam int DW   = 8;
    localparam int CW   = 3;
    localparam int W    = ROWS * DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  in_col;
    logic          low_rank;
    logic [CW-1:0] row_count;
    logic          out_valid;
    logic [W-1:0]  out_col;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic         q_v[$];
    logic [W-1:0] q_c[$];
    string        q_t[$];

    always #2 clk = ~clk;

    colsort_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
        .low_rank(low_rank), .row_count(row_count),
        .out_valid(out_valid), .out_col(out_col)
    );

    function automatic logic [W-1:0] pack5(int a, int b, int c, int d, int e);
        return {e[7:0], d[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    // behavioural reference: collect active samples, sort descending, fill from top
    function automatic logic [W-1:0] model(logic [W-1:0] col, int n, bit inv);
        int vals[ROWS];
        int k = 0;
        int t;
        logic [W-1:0] r = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (i < n) begin
                vals[k] = int'(col[i*DW +: DW] ^ {DW{inv}});
                k++;
            end
        end
        for (int i = 0; i < k; i++)
            for (int j = i + 1; j < k; j++)
                if (vals[j] > vals[i]) begin
                    t = vals[i]; vals[i] = vals[j]; vals[j] = t;
                end
        for (int j = 0; j < k; j++) r[(ROWS-1-j)*DW +: DW] = vals[j][7:0];
        return r;
    endfunction

    task automatic chk(string tag, logic [W:0] act, logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [W-1:0] col, int n, bit inv, string tag);
        logic [W-1:0] garbage;
        @(negedge clk);
        if (q_v.size() == ROWS) begin
            chk(q_t.pop_front(), {out_valid, out_col}, {q_v.pop_front(), q_c.pop_front()});
        end
        garbage   = {$urandom, $urandom};
        in_valid  = v;
        in_col    = v ? col : garbage;
        row_count = n[CW-1:0];
        low_rank  = inv;
        q_v.push_back(v);
        q_c.push_back(v ? model(col, n, inv) : '0);
        q_t.push_back(v ? tag : "R8");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_col = '1; low_rank = 1'b0; row_count = 3'd5;
        repeat (3) @(negedge clk);
        chk("R7", {out_valid, out_col}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7", {out_valid, out_col}, '0);
        rst_n = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            q_v.push_back(1'b0); q_c.push_back('0); q_t.push_back("R7");
        end

        // R1: distinct values
        step(1, pack5(10, 200, 55, 3, 99), 5, 0, "R1");
        step(1, pack5(1, 2, 3, 4, 5), 5, 0, "R1");
        step(1, pack5(250, 180, 90, 40, 0), 5, 0, "R1");
        // R3: duplicates and ties
        step(1, pack5(7, 7, 200, 7, 0), 5, 0, "R3");
        step(1, pack5(42, 42, 42, 42, 42), 5, 0, "R3");
        step(1, pack5(255, 0, 255, 0, 128), 5, 0, "R3");
        // R4: fewer rows, garbage on masked lanes
        step(1, pack5(9, 3, 6, 255, 254), 3, 0, "R4");
        step(1, pack5(77, 255, 255, 255, 255), 1, 0, "R4");
        step(1, pack5(4, 8, 2, 6, 255), 4, 0, "R4");
        // R5: zero and oversize counts
        step(1, pack5(11, 22, 33, 44, 55), 0, 0, "R5");
        step(1, pack5(60, 5, 30, 200, 1), 6, 0, "R5");
        step(1, pack5(3, 3, 9, 1, 8), 7, 0, "R5");
        // R6: inversion before sort
        step(1, pack5(10, 200, 55, 3, 99), 5, 1, "R6");
        step(1, pack5(0, 255, 16, 255, 255), 2, 1, "R6");
        // R8: bubbles with garbage in between
        step(0, '0, 5, 0, "R8");
        step(1, pack5(100, 50, 150, 25, 75), 5, 0, "R2");
        step(0, '0, 3, 1, "R8");
        step(0, '0, 5, 0, "R8");
        step(1, pack5(5, 4, 3, 2, 1), 5, 1, "R2");
        // R2: dense random stream
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] c;
            c = {$urandom, $urandom};
            if (k % 3 == 0) c = c & {ROWS{8'h0F}};
            step(($urandom % 5) != 0, c, int'($urandom % 8), bit'($urandom % 2), "R2");
        end
        for (int k = 0; k < ROWS + 1; k++) step(0, '0, 5, 0, "R8");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule